// File: doc/BRIEF.md
# DDR SDRAM command decoder

This block sits on the memory-device side of a four-bank double-data-rate SDRAM. On every rising clock edge it samples chip select, the row strobe, the column strobe, write enable, clock enable, the two bank-select bits and the address bus. Each legal command becomes a single registered one-hot strobe, which is visible one cycle after the edge that sampled it.

The block also keeps its own bookkeeping. For each bank it records whether the bank is open and which row was activated. It tracks the power state: normal, power-down or self-refresh. It captures the mode register written by a mode-set command. Illegal sequences, such as a read to a closed bank or an activate to an open bank, raise a sticky error and are otherwise dropped. The auto-precharge and close-all flag is address bit 8.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: In normal state, with clock enable high in the previous and the current cycle, a command is decoded. Chip select high is a deselect. With chip select low, {ras_n,cas_n,we_n} gives: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. An accepted command raises one bit of cmd_strobe one cycle after the sampling edge. The bits are: bit0 no-op or deselect, bit1 activate, bit2 read, bit3 write, bit4 precharge, bit5 burst stop, bit6 refresh, bit7 mode set. At most one bit is high.
- R2: Activate to a closed bank opens it and stores addr[10:0] as that bank's row, in open_rows[b*11 +: 11]. Activate to an open bank sets cmd_error, gives no strobe and leaves the bank state unchanged.
- R3: Read or write to an open bank strobes with cmd_bank = ba and cmd_col = addr[7:0]. When addr[8] is 1, cmd_auto_pre is 1 and the bank is closed after the command. Read or write to a closed bank sets cmd_error and gives no strobe.
- R4: Precharge with addr[8]=1 closes all banks and shows cmd_auto_pre=1. With addr[8]=0 it closes only bank ba. Precharging a closed bank is legal.
- R5: Refresh strobes only when all banks are closed. Otherwise it sets cmd_error and gives no strobe.
- R6: Mode set takes addr[2:0] as burst length (001 = 2, 010 = 4), addr[3] as burst type (0 sequential, 1 interleaved) and addr[6:4] as CAS latency (only 011 is accepted). Any other code sets cmd_error and leaves the mode outputs unchanged.
- R7: Clock enable falling with a refresh command, while all banks are closed, enters self-refresh (power_state 2). Clock enable high leaves it, back to normal. In self-refresh, any cycle with chip select low and a pattern other than 111 sets cmd_error. No strobe is given in self-refresh.
- R8: Clock enable falling with a no-op or deselect enters power-down (power_state 1). Clock enable high leaves it with nothing decoded in that cycle. While clock enable stays low, commands are ignored with no error. Clock enable falling with any other command, or with a refresh while a bank is open, sets cmd_error and the state stays normal.
- R9: cmd_error stays set until reset.
- R10: Asynchronous active-low reset gives no strobe, all banks closed, all rows 0, power_state 0, cmd_error 0, burst length 001, sequential, and CAS latency 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Row / column / opcode address bus |
| cmd_strobe | output | 8 | One-hot accepted-command strobe |
| cmd_bank | output | 2 | Bank of the last decoded command |
| cmd_col | output | 8 | Column of the last decoded command |
| cmd_auto_pre | output | 1 | Address bit 8 of the last decoded command |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 44 | Row per bank, bank b at [b*11 +: 11] |
| power_state | output | 2 | 0 normal, 1 power-down, 2 self-refresh |
| burst_len | output | 3 | Burst length code |
| burst_interleave | output | 1 | Burst type, 1 = interleaved |
| cas_latency | output | 3 | CAS latency code |
| cmd_error | output | 1 | Sticky illegal-sequence flag |

## Verification
The bench goes after these corner cases:
- An activate to an already open bank. A design that skipped this check would overwrite the stored row.
- A read carrying auto-precharge. A design that ignored it would leave the bank open, so the next activate would look like an error.
- A command held while clock enable rises out of power-down. A design that decoded it would open a bank one cycle early.
- A falling clock enable that carries a refresh while a bank is open. A design that did not check this would enter self-refresh with live rows.
- Mode codes with an unsupported latency or burst length. A design that stored them would change the mode outputs.
Long random runs, reset at intervals, compare every output against a bench model after every edge.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  typedef enum logic [3:0] {
    C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_BST, C_NOP, C_DESEL
  } cmd_e;

  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_PDOWN  = 2'd1,
    PS_SREF   = 2'd2
  } pstate_e;

  localparam int unsigned STB_W   = 8;
  localparam int unsigned STB_NOP = 0;
  localparam int unsigned STB_ACT = 1;
  localparam int unsigned STB_RD  = 2;
  localparam int unsigned STB_WR  = 3;
  localparam int unsigned STB_PRE = 4;
  localparam int unsigned STB_BST = 5;
  localparam int unsigned STB_REF = 6;
  localparam int unsigned STB_MRS = 7;

  localparam int unsigned OPC_W   = 7;
  localparam logic [2:0]  BL_TWO  = 3'b001;
  localparam logic [2:0]  BL_FOUR = 3'b010;
  localparam logic [2:0]  CL_THREE = 3'b011;

endpackage

// File: rtl/ddr_cmd_pin_decode.sv
module ddr_cmd_pin_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_REF;
        3'b010:  cmd = C_PRE;
        3'b011:  cmd = C_ACT;
        3'b100:  cmd = C_WR;
        3'b101:  cmd = C_RD;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_power_ctl.sv
module ddr_power_ctl
  import ddr_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cke,
  input  cmd_e    cmd,
  input  logic    all_closed,
  output logic    issue,
  output logic    pwr_err,
  output pstate_e pstate
);

  logic    cke_q;
  pstate_e st_q, st_d;

  wire idle_cmd = (cmd == C_DESEL) || (cmd == C_NOP);

  always_comb begin
    st_d    = st_q;
    issue   = 1'b0;
    pwr_err = 1'b0;
    case (st_q)
      PS_NORMAL: begin
        if (cke_q && cke) begin
          issue = 1'b1;
        end else if (cke_q && !cke) begin
          if (idle_cmd) begin
            st_d = PS_PDOWN;
          end else if ((cmd == C_REF) && all_closed) begin
            st_d = PS_SREF;
          end else begin
            pwr_err = 1'b1;
          end
        end
      end
      PS_PDOWN: begin
        if (cke) st_d = PS_NORMAL;
      end
      PS_SREF: begin
        if (!idle_cmd) pwr_err = 1'b1;
        if (cke) st_d = PS_NORMAL;
      end
      default: st_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
      st_q  <= PS_NORMAL;
    end else begin
      cke_q <= cke;
      st_q  <= st_d;
    end
  end

  assign pstate = st_q;

endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 11,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_en,
  input  logic [BANK_W-1:0]       act_bank,
  input  logic [ROW_W-1:0]        act_row,
  input  logic [NBANK-1:0]        close_mask,
  output logic [NBANK-1:0]        open_vec,
  output logic [NBANK*ROW_W-1:0]  rows
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             open_q, open_d;
    logic [ROW_W-1:0] row_q;
    logic             hit;

    assign hit = act_en && (act_bank == BANK_W'(b));

    always_comb begin
      open_d = open_q;
      if (close_mask[b]) open_d = 1'b0;
      if (hit)           open_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
      end else begin
        open_q <= open_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (hit) begin
        row_q <= act_row;
      end
    end

    assign open_vec[b]              = open_q;
    assign rows[b*ROW_W +: ROW_W]   = row_q;
  end

endmodule

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
  import ddr_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OPC_W-1:0] opcode,
  output logic             opcode_ok,
  output logic [2:0]       bl,
  output logic             bt,
  output logic [2:0]       cl
);

  logic [2:0] bl_q, cl_q;
  logic       bt_q;

  always_comb begin
    opcode_ok = ((opcode[2:0] == BL_TWO) || (opcode[2:0] == BL_FOUR)) &&
                (opcode[6:4] == CL_THREE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q <= BL_TWO;
      bt_q <= 1'b0;
      cl_q <= CL_THREE;
    end else if (load && opcode_ok) begin
      bl_q <= opcode[2:0];
      bt_q <= opcode[3];
      cl_q <= opcode[6:4];
    end
  end

  assign bl = bl_q;
  assign bt = bt_q;
  assign cl = cl_q;

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned AP_BIT = 8,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BANK_W-1:0]      ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [STB_W-1:0]       cmd_strobe,
  output logic [BANK_W-1:0]      cmd_bank,
  output logic [COL_W-1:0]       cmd_col,
  output logic                   cmd_auto_pre,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_rows,
  output logic [1:0]             power_state,
  output logic [2:0]             burst_len,
  output logic                   burst_interleave,
  output logic [2:0]             cas_latency,
  output logic                   cmd_error
);

  cmd_e    cmd;
  pstate_e pst;
  logic    issue, pwr_err, mode_ok;
  logic    act_en, mrs_load, dec_err;
  logic [NBANK-1:0] close_mask, open_v;
  logic [STB_W-1:0] stb_d, stb_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              ap_q, err_q, err_d;

  wire all_closed  = (open_v == '0);
  wire bank_is_open = open_v[ba];

  ddr_cmd_pin_decode u_pins (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  ddr_power_ctl u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd       (cmd),
    .all_closed(all_closed),
    .issue     (issue),
    .pwr_err   (pwr_err),
    .pstate    (pst)
  );

  ddr_bank_state #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_en    (act_en),
    .act_bank  (ba),
    .act_row   (addr),
    .close_mask(close_mask),
    .open_vec  (open_v),
    .rows      (open_rows)
  );

  ddr_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mrs_load),
    .opcode   (addr[OPC_W-1:0]),
    .opcode_ok(mode_ok),
    .bl       (burst_len),
    .bt       (burst_interleave),
    .cl       (cas_latency)
  );

  // legality of a decoded command against bank and mode state
  always_comb begin
    stb_d      = '0;
    act_en     = 1'b0;
    close_mask = '0;
    mrs_load   = 1'b0;
    dec_err    = 1'b0;
    if (issue) begin
      case (cmd)
        C_DESEL, C_NOP: stb_d[STB_NOP] = 1'b1;
        C_ACT: begin
          if (bank_is_open) begin
            dec_err = 1'b1;
          end else begin
            act_en         = 1'b1;
            stb_d[STB_ACT] = 1'b1;
          end
        end
        C_RD, C_WR: begin
          if (!bank_is_open) begin
            dec_err = 1'b1;
          end else begin
            if (cmd == C_RD) stb_d[STB_RD] = 1'b1;
            else             stb_d[STB_WR] = 1'b1;
            if (addr[AP_BIT]) close_mask = NBANK'(1) << ba;
          end
        end
        C_PRE: begin
          stb_d[STB_PRE] = 1'b1;
          close_mask = addr[AP_BIT] ? '1 : (NBANK'(1) << ba);
        end
        C_BST: stb_d[STB_BST] = 1'b1;
        C_REF: begin
          if (all_closed) stb_d[STB_REF] = 1'b1;
          else            dec_err = 1'b1;
        end
        C_MRS: begin
          mrs_load = 1'b1;
          if (mode_ok) stb_d[STB_MRS] = 1'b1;
          else         dec_err = 1'b1;
        end
        default: stb_d = '0;
      endcase
    end
  end

  always_comb begin
    err_d = err_q | dec_err | pwr_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      err_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
    end else if (issue) begin
      bank_q <= ba;
      col_q  <= addr[COL_W-1:0];
      ap_q   <= addr[AP_BIT];
    end
  end

  assign cmd_strobe   = stb_q;
  assign cmd_bank     = bank_q;
  assign cmd_col      = col_q;
  assign cmd_auto_pre = ap_q;
  assign bank_open    = open_v;
  assign power_state  = pst;
  assign cmd_error    = err_q;

endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
  parameter int unsigned BANK_W = 2,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cmd_strobe,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              cmd_auto_pre,
  input logic [NBANK-1:0]  bank_open,
  input logic [1:0]        power_state,
  input logic [2:0]        burst_len,
  input logic [2:0]        cas_latency,
  input logic              cmd_error
);

  logic [NBANK-1:0] sel;
  assign sel = NBANK'(1) << cmd_bank;

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe[1] |-> ((bank_open & sel) != '0) && (($past(bank_open) & sel) == '0));

  p_rw_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe[2] || cmd_strobe[3]) |-> (($past(bank_open) & sel) != '0));

  p_autopre_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_strobe[2] || cmd_strobe[3]) && cmd_auto_pre) |-> ((bank_open & sel) == '0));

  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe[4] && cmd_auto_pre) |-> (bank_open == '0));

  p_ref_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe[6] |-> ($past(bank_open) == '0));

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_latency == 3'b011) && ((burst_len == 3'b001) || (burst_len == 3'b010)));

  p_sref_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (power_state == 2'd2) |-> (cmd_strobe == '0));

  p_pdown_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (power_state == 2'd1) |-> (cmd_strobe == '0));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |=> cmd_error);

endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(.BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_strobe  (cmd_strobe),
  .cmd_bank    (cmd_bank),
  .cmd_auto_pre(cmd_auto_pre),
  .bank_open   (bank_open),
  .power_state (power_state),
  .burst_len   (burst_len),
  .cas_latency (cas_latency),
  .cmd_error   (cmd_error)
);

// File: tb/ddr_cmd_decoder_tb.sv
module ddr_cmd_decoder_tb;

  logic        clk, rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [10:0] addr;
  logic [7:0]  cmd_strobe;
  logic [1:0]  cmd_bank;
  logic [7:0]  cmd_col;
  logic        cmd_auto_pre;
  logic [3:0]  bank_open;
  logic [43:0] open_rows;
  logic [1:0]  power_state;
  logic [2:0]  burst_len;
  logic        burst_interleave;
  logic [2:0]  cas_latency;
  logic        cmd_error;

  ddr_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_strobe(cmd_strobe), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cmd_auto_pre(cmd_auto_pre), .bank_open(bank_open), .open_rows(open_rows),
    .power_state(power_state), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .cas_latency(cas_latency),
    .cmd_error(cmd_error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [3:0]  m_open;
  logic [10:0] m_row [4];
  logic [1:0]  m_ps;
  logic        m_err, m_ckeq, m_bt;
  logic [2:0]  m_bl, m_cl;

  function automatic bit mode_valid(input logic [10:0] a);
    return ((a[2:0] == 3'b001) || (a[2:0] == 3'b010)) && (a[6:4] == 3'b011);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [7:0] es);
    logic [43:0] er;
    for (int b = 0; b < 4; b++) er[b*11 +: 11] = m_row[b];
    check(tag, {42'd0, cmd_strobe, bank_open, power_state, cmd_error,
                burst_len, burst_interleave, cas_latency},
               {42'd0, es, m_open, m_ps, m_err, m_bl, m_bt, m_cl});
    check(tag, {20'd0, open_rows}, {20'd0, er});
  endtask

  task automatic model_reset();
    m_open = '0;
    for (int b = 0; b < 4; b++) m_row[b] = '0;
    m_ps = 2'd0; m_err = 0; m_ckeq = 1;
    m_bl = 3'b001; m_bt = 0; m_cl = 3'b011;
  endtask

  task automatic do_reset();
    rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    check_all("R10 reset state", 8'h00);
  endtask

  // drive at a falling edge, check after the next rising edge
  task automatic step(input string tag, input logic k, input logic c,
                      input logic [2:0] rcw, input logic [1:0] b, input logic [10:0] a);
    logic [7:0] es;
    logic       idle;
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    es = '0;
    idle = c || (rcw == 3'b111);
    case (m_ps)
      2'd0: begin
        if (m_ckeq && k) begin
          if (idle) es[0] = 1;
          else case (rcw)
            3'b011: if (m_open[b]) m_err = 1;
                    else begin m_open[b] = 1; m_row[b] = a; es[1] = 1; end
            3'b101, 3'b100: if (!m_open[b]) m_err = 1;
                    else begin
                      es[(rcw == 3'b101) ? 2 : 3] = 1;
                      if (a[8]) m_open[b] = 0;
                    end
            3'b010: begin es[4] = 1; if (a[8]) m_open = '0; else m_open[b] = 0; end
            3'b110: es[5] = 1;
            3'b001: if (m_open == '0) es[6] = 1; else m_err = 1;
            default: if (mode_valid(a)) begin
                       es[7] = 1; m_bl = a[2:0]; m_bt = a[3]; m_cl = a[6:4];
                     end else m_err = 1;
          endcase
        end else if (m_ckeq && !k) begin
          if (idle) m_ps = 2'd1;
          else if ((rcw == 3'b001) && (m_open == '0)) m_ps = 2'd2;
          else m_err = 1;
        end
      end
      2'd1: if (k) m_ps = 2'd0;
      default: begin
        if (!idle) m_err = 1;
        if (k) m_ps = 2'd0;
      end
    endcase
    m_ckeq = k;
    @(posedge clk);
    #1;
    check_all(tag, es);
    if (es[2] || es[3] || es[4])
      check(tag, {53'd0, cmd_bank, cmd_col, cmd_auto_pre}, {53'd0, b, a[7:0], a[8]});
    @(negedge clk);
  endtask

  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011,
                         WR = 3'b100, RD = 3'b101, BST = 3'b110, NOP = 3'b111;

  initial begin
    rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    model_reset();
    @(negedge clk);
    do_reset();

    // group A: decode and bank tracking
    step("R1 nop",              1, 0, NOP, 0, 11'h000);
    step("R1 deselect",         1, 1, MRS, 0, 11'h000);
    step("R6 mode set BL4 il",  1, 0, MRS, 0, 11'b000_0011_1010);
    step("R1 burst stop",       1, 0, BST, 0, 11'h000);
    step("R2 activate b1",      1, 0, ACT, 1, 11'h5A5);
    step("R3 read b1",          1, 0, RD,  1, 11'h033);
    step("R3 write b1 autopre", 1, 0, WR,  1, 11'h1C4);
    step("R3 read after autopre", 1, 0, RD, 1, 11'h010);
    step("R9 error sticky",     1, 0, NOP, 0, 11'h000);

    do_reset();
    step("R2 activate b2",      1, 0, ACT, 2, 11'h7FF);
    step("R2 activate b3",      1, 0, ACT, 3, 11'h001);
    step("R4 precharge b2",     1, 0, PRE, 2, 11'h000);
    step("R5 refresh with open bank", 1, 0, REF, 0, 11'h000);
    do_reset();
    step("R2 activate b0",      1, 0, ACT, 0, 11'h123);
    step("R2 activate b3",      1, 0, ACT, 3, 11'h456);
    step("R4 precharge all",    1, 0, PRE, 1, 11'h100);
    step("R5 refresh all closed", 1, 0, REF, 0, 11'h000);
    step("R2 activate b0",      1, 0, ACT, 0, 11'h222);
    step("R2 activate open b0", 1, 0, ACT, 0, 11'h333);

    do_reset();
    step("R6 bad latency",      1, 0, MRS, 0, 11'b000_0010_0010);
    do_reset();
    step("R6 bad burst length", 1, 0, MRS, 0, 11'b000_0011_0011);

    // power-down
    do_reset();
    step("R8 enter power-down", 0, 0, NOP, 0, 11'h000);
    step("R8 read ignored",     0, 0, RD,  0, 11'h000);
    step("R8 exit, act dropped", 1, 0, ACT, 1, 11'h0AA);
    step("R8 activate after exit", 1, 0, ACT, 1, 11'h0AB);
    step("R8 cke fall with read", 0, 0, RD, 1, 11'h000);

    // self-refresh
    do_reset();
    step("R7 enter self-refresh", 0, 0, REF, 0, 11'h000);
    step("R7 nop in self-refresh", 0, 0, NOP, 0, 11'h000);
    step("R7 exit self-refresh", 1, 1, NOP, 0, 11'h000);
    step("R7 command after exit", 1, 0, ACT, 2, 11'h321);
    step("R8 refresh fall with open bank", 0, 0, REF, 0, 11'h000);
    do_reset();
    step("R7 enter self-refresh", 0, 0, REF, 0, 11'h000);
    step("R7 activate in self-refresh", 0, 0, ACT, 0, 11'h000);

    // random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic       k, c;
      logic [2:0] r;
      if ((i % 50) == 0) do_reset();
      k = ($urandom_range(0, 9) != 0);
      c = ($urandom_range(0, 7) == 0);
      r = 3'($urandom_range(0, 7));
      if ((r == MRS) && ($urandom_range(0, 1) == 0)) r = NOP;
      step("random R1,R2,R3,R4,R5,R6,R7,R8", k, c, r, 2'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0) ? {4'd0, 7'b011_0010} : 11'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule